// File: doc/BRIEF.md
# Daisy-Chainable Serial Potentiometer Controller

This block is the digital front end of a multi-channel digital potentiometer. A host writes it over a three-wire serial port made of a serial clock, an active-low select and a data line. Each frame is 11 bits: a 3-bit channel address followed by an 8-bit wiper code, both sent most-significant bit first. When the select line is released, the addressed wiper latch takes the 8-bit code. The rest of the chip reads the wiper codes and one terminal-open flag per channel.

Each bit that falls off the end of the shift register goes to an open-drain serial output. The output of one device can feed the data input of the next, so that a single long frame programs a whole chain. An active-low preset input returns every wiper to midscale. An active-low shutdown input releases the serial output and flags every channel as open. All serial pins are sampled by the block clock `clk`, which must run several times faster than the serial clock. `clk` detects serial clock rises and select releases as edges.

Top module: `serial_pot_ctrl`

## Requirements
- R1: Each rising edge of `sclk` seen while `cs_n` is low shifts `sdi` into an 11-bit register. The frame is sent most-significant bit first: address bits 2, 1, 0, then data bits 7 down to 0.
- R2: A low-to-high transition of `cs_n` loads the last 8 bits shifted in into the wiper latch selected by the first 3 bits. Address code k drives `wiper_codes[8k+7:8k]`. All other latches keep their values.
- R3: Address codes at or above the channel count `NCH` (default 4, so codes 100, 101, 110 and 111) leave every wiper latch unchanged.
- R4: `sclk` edges while `cs_n` is high do not alter the shift register. A later select frame that carries no clocks reloads the previously held word.
- R5: Each shift moves the bit entered 11 shifts earlier into the output latch. In a 22-bit frame, the first 11 bits therefore appear on `sdo_level` during shifts 12 to 22, in order.
- R6: While `preset_n` is low, every wiper latch is forced to 0x80 and the output latch is cleared. As a result, the output pulls low whenever the select is low.
- R7: While `shdn_n` is low, `sdo_pull_low` is 0 and `sdo_level` is 1, and every `term_a_open` bit is 1. The wiper codes are kept and remain valid after shutdown ends.
- R8: While `cs_n` is high, the serial output is released (`sdo_pull_low` = 0, `sdo_level` = 1).
- R9: After reset, every wiper code is 0x80 and every `term_a_open` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; rising edges shift data |
| cs_n | input | 1 | Active-low select; rising edge loads a latch |
| sdi | input | 1 | Serial data in |
| preset_n | input | 1 | Active-low preset to midscale |
| shdn_n | input | 1 | Active-low shutdown |
| wiper_codes | output | NCH*8 | Wiper codes, channel k at bits 8k+7:8k |
| term_a_open | output | NCH | Per-channel flag: A terminal open, wiper tied to B |
| sdo_pull_low | output | 1 | Open-drain enable for the serial output |
| sdo_level | output | 1 | Resolved serial output level with an assumed pull-up |

## Verification
A corrupted shift register stays hidden until the next select release, or until 11 more shifts push its contents out on `sdo_level`. The daisy-chain test therefore compares the output bit by bit over the second half of a 22-bit frame. A wrong address decode or a wrong latch value shows up on `wiper_codes` one `clk` cycle after `cs_n` rises, so every write is followed by a readback of all channels. The test of clocks with the select high uses an empty frame to reload the held word. This exposes any shift that should not have happened, even though the register has no port of its own.

// File: rtl/serial_pot_ctrl.sv
module serial_pot_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 3,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              preset_n,
  input  logic              shdn_n,
  output logic [NCH*DW-1:0] wiper_codes,
  output logic [NCH-1:0]    term_a_open,
  output logic              sdo_pull_low,
  output logic              sdo_level
);
  localparam int FW = AW + DW;
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic          sclk_q, cs_q, sdo_q;
  logic [FW-1:0] sr;

  wire shift_en = sclk & ~sclk_q & ~cs_n;
  wire load_en  = cs_n & ~cs_q;
  wire [AW-1:0] addr = sr[FW-1 -: AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sr     <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (shift_en) sr <= {sr[FW-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sdo_q <= 1'b1;
    else if (!preset_n) sdo_q <= 1'b0;
    else if (shift_en)  sdo_q <= sr[FW-1];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] lat;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            lat <= MID;
      else if (!preset_n)                    lat <= MID;
      else if (load_en && addr == AW'(i))    lat <= sr[DW-1:0];
    end
    assign wiper_codes[i*DW +: DW] = lat;
    assign term_a_open[i]          = ~shdn_n;
  end

  assign sdo_pull_low = ~cs_n & shdn_n & ~sdo_q;
  assign sdo_level    = ~sdo_pull_low;
endmodule

// File: rtl/serial_pot_ctrl_chk.sv
module serial_pot_ctrl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              preset_n,
  input logic              shdn_n,
  input logic [NCH*DW-1:0] wiper_codes,
  input logic              sdo_pull_low,
  input logic              sdo_level
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  assert_preset_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |=> wiper_codes == {NCH{MID}});

  assert_shdn_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (!sdo_pull_low && sdo_level));

  assert_cs_high_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_pull_low);

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && preset_n) |=> $stable(wiper_codes));

  assert_level_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_level != sdo_pull_low);
endmodule

bind serial_pot_ctrl serial_pot_ctrl_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .preset_n(preset_n), .shdn_n(shdn_n),
  .wiper_codes(wiper_codes), .sdo_pull_low(sdo_pull_low), .sdo_level(sdo_level)
);

// File: tb/serial_pot_ctrl_tb_top.sv
`timescale 1ns/100ps
module serial_pot_ctrl_tb_top;
  localparam int NCH = 4;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic preset_n = 1'b1, shdn_n = 1'b1;
  logic [NCH*8-1:0] wiper_codes;
  logic [NCH-1:0]   term_a_open;
  logic             sdo_pull_low, sdo_level;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] model [NCH];

  always #2.5 clk = ~clk;

  serial_pot_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .preset_n(preset_n), .shdn_n(shdn_n), .wiper_codes(wiper_codes),
    .term_a_open(term_a_open), .sdo_pull_low(sdo_pull_low), .sdo_level(sdo_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; sclk = 1'b0; wait_neg(2);
    sclk = 1'b1; wait_neg(2);
    sclk = 1'b0;
  endtask

  task automatic send_word(input logic [2:0] a, input logic [7:0] d);
    logic [10:0] w = {a, d};
    cs_n = 1'b0; wait_neg(2);
    for (int i = 10; i >= 0; i--) shift_bit(w[i]);
    wait_neg(1); cs_n = 1'b1; wait_neg(3);
    if (a < NCH) model[a] = d;
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NCH; k++) chk(req, 32'(wiper_codes[k*8 +: 8]), 32'(model[k]));
  endtask

  task automatic t_reset;
    for (int k = 0; k < NCH; k++) model[k] = 8'h80;
    check_all("R9 reset wiper");
    chk("R9 reset flags", 32'(term_a_open), 0);
    chk("R8 released at idle", 32'(sdo_pull_low), 0);
  endtask

  task automatic t_writes;
    send_word(3'd0, 8'h11); check_all("R1 R2 write ch0");
    send_word(3'd2, 8'hA5); check_all("R2 write ch2");
    send_word(3'd3, 8'hFF); check_all("R2 write ch3");
    send_word(3'd1, 8'h00); check_all("R1 R2 write ch1");
  endtask

  task automatic t_bad_addr;
    send_word(3'b100, 8'h3C); check_all("R3 addr 100");
    send_word(3'b101, 8'h3C); check_all("R3 addr 101");
    send_word(3'b110, 8'h3C); check_all("R3 addr 110");
    send_word(3'b111, 8'h3C); check_all("R3 addr 111");
  endtask

  task automatic t_clk_cs_high;
    send_word(3'd0, 8'h5A);
    preset_n = 1'b0; wait_neg(3); preset_n = 1'b1; wait_neg(1);
    for (int k = 0; k < NCH; k++) model[k] = 8'h80;
    check_all("R6 preset midscale");
    for (int i = 0; i < 11; i++) shift_bit(1'b1);
    cs_n = 1'b0; wait_neg(3);
    chk("R6 output latch cleared pulls low", 32'(sdo_level), 0);
    chk("R6 pull enable", 32'(sdo_pull_low), 1);
    cs_n = 1'b1; wait_neg(3);
    model[0] = 8'h5A;
    check_all("R4 held word reloaded");
  endtask

  task automatic t_daisy;
    logic [21:0] s = {3'd1, 8'hC3, 3'd2, 8'h6B};
    cs_n = 1'b0; wait_neg(2);
    for (int i = 21; i >= 0; i--) begin
      shift_bit(s[i]);
      wait_neg(1);
      if (i <= 10) chk("R5 daisy output", 32'(sdo_level), 32'(s[i + 11]));
    end
    cs_n = 1'b1; wait_neg(3);
    model[2] = 8'h6B;
    check_all("R5 own word loaded");
    chk("R8 released after frame", 32'(sdo_pull_low), 0);
  endtask

  task automatic t_shutdown;
    preset_n = 1'b0; wait_neg(2); preset_n = 1'b1;
    for (int k = 0; k < NCH; k++) model[k] = 8'h80;
    send_word(3'd3, 8'h27);
    preset_n = 1'b0; wait_neg(2); preset_n = 1'b1;
    for (int k = 0; k < NCH; k++) model[k] = 8'h80;
    send_word(3'd3, 8'h27);
    cs_n = 1'b0; wait_neg(2);
    shdn_n = 1'b0; wait_neg(2);
    chk("R7 output off", 32'(sdo_level), 1);
    chk("R7 pull off", 32'(sdo_pull_low), 0);
    chk("R7 flags set", 32'(term_a_open), {NCH{1'b1}});
    check_all("R7 wipers kept");
    shdn_n = 1'b1; wait_neg(2);
    chk("R7 flags clear", 32'(term_a_open), 0);
    check_all("R7 wipers after release");
    cs_n = 1'b1; wait_neg(2);
  endtask

  initial begin
    wait_neg(3); rst_n = 1'b1; wait_neg(2);
    t_reset();
    t_writes();
    t_bad_addr();
    t_clk_cs_high();
    t_daisy();
    t_shutdown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule